// File: doc/BRIEF.md
# Spread-Spectrum Frequency Word Modulator

This block sweeps the frequency control word of a phase-accumulator oscillator slowly up and down around a programmed value, so that the energy of the generated clock is spread over a narrow band instead of sitting at one spectral line. A triangular profile steps the word in small increments. One full sweep lasts a fixed multiple of the clock. The peak deviation is the nominal word scaled by a small fixed fraction. A one-bit width select picks about 0.625 % or about 2.5 %. A mode input chooses a band centred on the nominal word, or a band that hangs below it with the nominal word as a hard ceiling.

The same block holds the accumulator. Its most significant bit is the square clock output. A two-bit range select scales how slow the sweep is, so that the sweep stays roughly a thousand output periods long across ranges. Code 00 of this select is reserved. An active-low enable turns the sweep off and leaves the plain nominal word. Configuration inputs are sampled only where one sweep ends and the next begins, so the band never jumps halfway through a sweep.

Top module: `ssc_mod_top`

## Requirements
- R1: While rst_n is low, freq_word is 0, clk_out is 0 and range_err is 0.
- R2: With spread_n high, freq_word equals nom_word from the second rising edge after the inputs are applied, in either mode.
- R3: Centre mode (down_mode=0), width_sel=0, spreading: over one sweep the minimum is nom−D and the maximum is nom+D, where D = floor(nom·26/4096).
- R4: Centre mode, width_sel=1: same bounds with D = floor(nom·102/4096).
- R5: In centre mode the sum of freq_word over any window of exactly one sweep period equals period·nom.
- R6: Down mode (down_mode=1): freq_word never exceeds nom. Over one sweep the maximum is nom and the minimum is nom−2D.
- R7: The sweep period is 4·QSTEPS·DWELL·m clocks, with m=1 for range_sel=11, m=2 for 10 and m=4 for 01. The peak value is held for DWELL·m consecutive clocks in each period.
- R8: Changes of width_sel, down_mode, range_sel or nom_word while spreading take effect only at the next sweep boundary.
- R9: range_sel=00 is reserved. One clock later range_err is 1, and no new configuration is taken, so the previous sweep continues unchanged. range_err returns to 0 one clock after a valid code is applied.
- R10: clk_out is the MSB of an FW-bit accumulator that adds freq_word every clock. Over M clocks with constant word w, where M·w is a multiple of 2^FW, it rises exactly M·w/2^FW times.
- R11: With spread_n low at reset release, the first sweep starts at once using the inputs present then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nom_word | input | FW | Nominal (or ceiling, in down mode) frequency word |
| range_sel | input | 2 | Sweep-rate range: 01 slow, 10 middle, 11 fast, 00 reserved |
| width_sel | input | 1 | 0: narrow deviation, 1: wide deviation |
| down_mode | input | 1 | 0: band centred on nom_word, 1: band below nom_word |
| spread_n | input | 1 | Active-low sweep enable |
| freq_word | output | FW | Instantaneous frequency word |
| clk_out | output | 1 | Square clock from the accumulator MSB |
| range_err | output | 1 | Reserved range code present |

## Verification
Two events can land on the same clock: a sweep boundary that loads a new configuration, and a configuration request arriving in mid-sweep or carrying the reserved range code. The bench raises the width select at the moment the sweep peak appears, then confirms that the following hundred-odd words stay inside the narrow band. It then confirms that the wide band is in force after the boundary. The bench also presents the reserved code together with a new nominal word across several boundaries. It judges that the old band's minimum, maximum, mean and peak dwell are unchanged, and that the new word is taken once a valid code returns.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int unsigned FRAC_BITS = 12;
  localparam int unsigned K_NARROW  = 26;
  localparam int unsigned K_WIDE    = 102;
  localparam int unsigned K_W       = 7;

  typedef enum logic [1:0] {
    RNG_RSVD = 2'b00,
    RNG_SLOW = 2'b01,
    RNG_MID  = 2'b10,
    RNG_FAST = 2'b11
  } range_e;

  function automatic logic [1:0] rate_shift_of(input logic [1:0] code);
    case (code)
      RNG_SLOW: rate_shift_of = 2'd2;
      RNG_MID:  rate_shift_of = 2'd1;
      default:  rate_shift_of = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/ssc_profile.sv
module ssc_profile #(
  parameter int QSTEPS = 8,
  parameter int DWELL  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         run,
  input  logic [1:0]                   rate_shift,
  output logic signed [$clog2(QSTEPS)+1:0] tval,
  output logic                         period_end
);
  localparam int QLOG = $clog2(QSTEPS);
  localparam int PH_N = 4 * QSTEPS;
  localparam int PH_W = $clog2(PH_N);
  localparam int TW   = QLOG + 2;
  localparam int DC_W = $clog2(DWELL * 4);

  logic [DC_W-1:0] dc_q, dc_d, lim_last;
  logic [PH_W-1:0] ph_q, ph_d;
  logic            step;
  logic signed [PH_W+1:0] phs, tcalc;

  always_comb begin
    lim_last   = DC_W'((DWELL << rate_shift) - 1);
    step       = run && (dc_q == lim_last);
    period_end = step && (ph_q == PH_W'(PH_N - 1));
  end

  always_comb begin
    dc_d = dc_q;
    ph_d = ph_q;
    if (!run) begin
      dc_d = '0;
      ph_d = '0;
    end else if (step) begin
      dc_d = '0;
      ph_d = ph_q + PH_W'(1);
    end else begin
      dc_d = dc_q + DC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dc_q <= '0;
      ph_q <= '0;
    end else begin
      dc_q <= dc_d;
      ph_q <= ph_d;
    end
  end

  always_comb begin
    phs = $signed({2'b00, ph_q});
    if (ph_q < PH_W'(QSTEPS))
      tcalc = phs;
    else if (ph_q < PH_W'(3 * QSTEPS))
      tcalc = $signed((PH_W+2)'(2 * QSTEPS)) - phs;
    else
      tcalc = phs - $signed((PH_W+2)'(4 * QSTEPS));
    tval = $signed(tcalc[TW-1:0]);
  end

  // R7: the phase advances by at most one level per clock
  assert_phase_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> ((ph_q == $past(ph_q)) || (ph_q == $past(ph_q) + PH_W'(1))));

  // R7: a level is left only after its full dwell
  assert_dwell_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && (ph_q != $past(ph_q))) |-> ($past(dc_q) == $past(lim_last)));
endmodule

// File: rtl/ssc_deviate.sv
module ssc_deviate
  import ssc_pkg::*;
#(
  parameter int FW   = 24,
  parameter int QLOG = 3
) (
  input  logic [FW-1:0]          nom,
  input  logic                   wide,
  input  logic                   down,
  input  logic signed [QLOG+1:0] tval,
  output logic [FW-1:0]          word
);
  localparam int TW = QLOG + 2;
  localparam int PW = FW + K_W;

  logic [K_W-1:0]   kval;
  logic [PW-1:0]    prod;
  logic [FW-1:0]    dev, offm;
  logic [TW-1:0]    mag;
  logic [FW+TW-1:0] mprod;
  logic             neg;
  logic [FW:0]      sum, lower;

  always_comb begin
    kval  = wide ? K_W'(K_WIDE) : K_W'(K_NARROW);
    prod  = {{K_W{1'b0}}, nom} * {{FW{1'b0}}, kval};
    dev   = FW'(prod >> FRAC_BITS);
    neg   = tval[TW-1];
    mag   = neg ? $unsigned(-tval) : $unsigned(tval);
    mprod = {{TW{1'b0}}, dev} * {{FW{1'b0}}, mag};
    offm  = FW'(mprod >> QLOG);
    lower = '0;
    if (!down) begin
      sum = neg ? ({1'b0, nom} - {1'b0, offm}) : ({1'b0, nom} + {1'b0, offm});
      word = sum[FW] ? (neg ? '0 : '1) : sum[FW-1:0];
    end else begin
      lower = neg ? ({1'b0, dev} + {1'b0, offm}) : ({1'b0, dev} - {1'b0, offm});
      sum   = {1'b0, nom} - lower;
      word  = sum[FW] ? '0 : sum[FW-1:0];
    end
  end
endmodule

// File: rtl/ssc_nco.sv
module ssc_nco #(
  parameter int FW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] word,
  output logic          clk_out
);
  logic [FW-1:0] acc_q, acc_d;

  always_comb acc_d = acc_q + word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign clk_out = acc_q[FW-1];

  // R10: a zero word freezes the output clock
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(word) == '0) |-> $stable(clk_out));
endmodule

// File: rtl/ssc_mod_top.sv
module ssc_mod_top
  import ssc_pkg::*;
#(
  parameter int FW     = 24,
  parameter int QSTEPS = 8,
  parameter int DWELL  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] nom_word,
  input  logic [1:0]    range_sel,
  input  logic          width_sel,
  input  logic          down_mode,
  input  logic          spread_n,
  output logic [FW-1:0] freq_word,
  output logic          clk_out,
  output logic          range_err
);
  localparam int QLOG = $clog2(QSTEPS);
  localparam int TW   = QLOG + 2;

  logic          first_q;
  logic [FW-1:0] nom_a;
  logic [1:0]    range_a;
  logic          wide_a, down_a;
  logic [FW-1:0] freq_q, freq_d, mod_word;
  logic          err_q;
  logic          load, take, period_end;
  logic signed [TW-1:0] tval;

  ssc_profile #(.QSTEPS(QSTEPS), .DWELL(DWELL)) u_prof (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (!spread_n),
    .rate_shift (rate_shift_of(range_a)),
    .tval       (tval),
    .period_end (period_end)
  );

  ssc_deviate #(.FW(FW), .QLOG(QLOG)) u_dev (
    .nom  (nom_a),
    .wide (wide_a),
    .down (down_a),
    .tval (tval),
    .word (mod_word)
  );

  ssc_nco #(.FW(FW)) u_nco (
    .clk     (clk),
    .rst_n   (rst_n),
    .word    (freq_q),
    .clk_out (clk_out)
  );

  always_comb begin
    load   = first_q || spread_n || period_end;
    take   = load && (range_sel != RNG_RSVD);
    freq_d = spread_n ? nom_a : mod_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      nom_a   <= '0;
      range_a <= RNG_FAST;
      wide_a  <= 1'b0;
      down_a  <= 1'b0;
      freq_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      first_q <= 1'b0;
      freq_q  <= freq_d;
      err_q   <= (range_sel == RNG_RSVD);
      if (take) begin
        nom_a   <= nom_word;
        range_a <= range_sel;
        wide_a  <= width_sel;
        down_a  <= down_mode;
      end
    end
  end

  assign freq_word = freq_q;
  assign range_err = err_q;

  // R6: down-spread output never above the ceiling
  assert_down_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(down_a) && !$past(spread_n)) |-> (freq_word <= $past(nom_a)));

  // R8: active configuration moves only on a load cycle
  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load) |-> ($stable(nom_a) && $stable(wide_a) && $stable(range_a) && $stable(down_a)));

  // R9: the reserved code never becomes the active range
  assert_no_rsvd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    range_a != RNG_RSVD);

  // R9: a flagged reserved code blocks the load it coincided with
  assert_rsvd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (range_err && $past(load)) |-> $stable(nom_a));
endmodule

// File: tb/sim_ssc_mod_top.sv
module sim_ssc_mod_top;
  localparam int FW = 24;
  localparam int QS = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [FW-1:0] nom_word;
  logic [1:0]    range_sel;
  logic          width_sel, down_mode, spread_n;
  logic [FW-1:0] freq_word;
  logic          clk_out, range_err;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  ssc_mod_top #(.FW(FW), .QSTEPS(QS), .DWELL(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .nom_word(nom_word), .range_sel(range_sel),
    .width_sel(width_sel), .down_mode(down_mode), .spread_n(spread_n),
    .freq_word(freq_word), .clk_out(clk_out), .range_err(range_err)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic longint devof(input longint nom, input bit wide);
    return (nom * (wide ? 102 : 26)) / 4096;
  endfunction

  function automatic int multof(input logic [1:0] r);
    return (r == 2'b11) ? 1 : ((r == 2'b10) ? 2 : 4);
  endfunction

  task automatic verify_case(input longint nom, input bit wide, input bit down, input logic [1:0] r);
    longint smp[0:1023];
    longint mn, mx, sum, d;
    int p, nmax;
    string req;
    p = 4 * QS * DW * multof(r);
    mn = 64'h7fffffffffffffff; mx = -1; sum = 0; nmax = 0;
    for (int i = 0; i < p; i++) begin
      @(negedge clk);
      smp[i] = longint'(freq_word);
      sum += smp[i];
      if (smp[i] < mn) mn = smp[i];
      if (smp[i] > mx) mx = smp[i];
    end
    for (int i = 0; i < p; i++) if (smp[i] == mx) nmax++;
    d = devof(nom, wide);
    req = down ? "R6" : (wide ? "R4" : "R3");
    if (down) begin
      chk(mx == nom, {req, " max"}, mx, nom);
      chk(mn == nom - 2 * d, {req, " min"}, mn, nom - 2 * d);
    end else begin
      chk(mx == nom + d, {req, " max"}, mx, nom + d);
      chk(mn == nom - d, {req, " min"}, mn, nom - d);
      chk(sum == longint'(p) * nom, "R5 mean", sum, longint'(p) * nom);
    end
    chk(nmax == DW * multof(r), "R7 peak dwell", nmax, DW * multof(r));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seen, viol, rises;
    logic prev;
    longint n0, dn;
    rst_n = 1'b0; nom_word = 24'h400000; range_sel = 2'b11;
    width_sel = 1'b0; down_mode = 1'b0; spread_n = 1'b0;
    n0 = 64'h400000;
    tick(3);
    chk(freq_word == '0, "R1 freq", freq_word, 0);
    chk(clk_out == 1'b0, "R1 clk_out", clk_out, 0);
    chk(range_err == 1'b0, "R1 range_err", range_err, 0);
    rst_n = 1'b1;

    // R11: sweep starts from reset release with the present inputs
    seen = 0;
    for (int i = 0; i < 260; i++) begin
      @(negedge clk);
      if (longint'(freq_word) == n0 + devof(n0, 0)) seen = 1;
    end
    chk(seen == 1, "R11 first sweep peak", seen, 1);
    tick(260);
    verify_case(n0, 0, 0, 2'b11);

    width_sel = 1'b1; tick(2 * 256 + 4);
    verify_case(n0, 1, 0, 2'b11);
    down_mode = 1'b1; tick(2 * 256 + 4);
    verify_case(n0, 1, 1, 2'b11);
    down_mode = 1'b0; range_sel = 2'b10; tick(2 * 512 + 4);
    verify_case(n0, 1, 0, 2'b10);
    range_sel = 2'b01; tick(2 * 1024 + 4);
    verify_case(n0, 1, 0, 2'b01);
    width_sel = 1'b0; range_sel = 2'b11; tick(2 * 1024 + 4);
    verify_case(n0, 0, 0, 2'b11);

    // R8: width raised at the sweep peak must not act mid-sweep
    dn = devof(n0, 0);
    seen = 0;
    for (int i = 0; i < 300 && seen == 0; i++) begin
      @(negedge clk);
      if (longint'(freq_word) == n0 + dn) seen = 1;
    end
    chk(seen == 1, "R8 peak found", seen, 1);
    width_sel = 1'b1;
    viol = 0;
    for (int i = 0; i < 126; i++) begin
      @(negedge clk);
      if (longint'(freq_word) > n0 + dn || longint'(freq_word) < n0 - dn) viol++;
    end
    chk(viol == 0, "R8 no mid-sweep change", viol, 0);
    tick(2 * 256 + 4);
    verify_case(n0, 1, 0, 2'b11);

    // R9: reserved range holds the old sweep
    nom_word = 24'h200000; range_sel = 2'b00;
    tick(4);
    chk(range_err == 1'b1, "R9 flag set", range_err, 1);
    tick(2 * 256);
    verify_case(n0, 1, 0, 2'b11);
    range_sel = 2'b11;
    tick(3);
    chk(range_err == 1'b0, "R9 flag clear", range_err, 0);
    tick(2 * 256 + 4);
    n0 = 64'h200000;
    verify_case(n0, 1, 0, 2'b11);

    // R2: spread off gives the plain nominal word
    spread_n = 1'b1; nom_word = 24'h100000;
    tick(3);
    viol = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (freq_word != 24'h100000) viol++;
    end
    chk(viol == 0, "R2 constant word", viol, 0);
    down_mode = 1'b1; tick(3);
    chk(freq_word == 24'h100000, "R2 down mode off", freq_word, 24'h100000);
    down_mode = 1'b0;

    // R10: accumulator MSB rise count
    tick(3);
    prev = clk_out; rises = 0;
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      if (clk_out && !prev) rises++;
      prev = clk_out;
    end
    chk(rises == 64, "R10 rises w=0x100000", rises, 64);
    nom_word = 24'h080000; tick(3);
    prev = clk_out; rises = 0;
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      if (clk_out && !prev) rises++;
      prev = clk_out;
    end
    chk(rises == 32, "R10 rises w=0x080000", rises, 32);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule